// File: doc/BRIEF.md
# Secondary Bus Round-Robin Arbiter

This block decides which of several PCI-style masters on a secondary bus may start the next transaction. Each master asks for the bus with an active-low request line and gets back an active-low grant line. The arbiter watches FRAME# and IRDY# to tell when the bus is free and when the granted master has actually begun a transfer. A new grant is issued only on an idle bus. Masters are served in rotating order, and when nobody asks the bus is parked on master 0.

Two counters limit how long a master keeps its grant. The fairness counter is reloaded with a programmable value each time a grant is issued. It starts counting down only after the owner first drives FRAME# low. Once it runs out while another master is waiting, the grant is taken back. A programmable value of zero turns this limit off. The optional broken-master timeout takes back a grant that a requesting master never uses: it fires after 16 idle clocks with no FRAME#.

A 16-bit register holds the fairness reload value and the timeout enable. Its lowest bit reports whether a strap, sampled during reset, handed control to an external arbiter. In that mode every grant stays inactive.

Top module: `sec_bus_arbiter`

## Requirements
- R1: While rst_n is low every gnt_n bit is high. After a reset with strap_ext low, cfg_rd_data reads 0x0800.
- R2: The register layout is as follows. Bits 15:8 hold the fairness reload value (read/write). Bit 1 is the broken-master timeout enable (read/write). Bit 0 is the read-only mode status. Bits 7:2 read as zero. When cfg_wr_en is high at a clock edge, the writable fields take their values from cfg_wr_data.
- R3: At most one gnt_n bit is low at any time. When the grant moves from one master to another, at least one clock passes with all gnt_n bits high.
- R4: A grant is asserted only at a clock edge where no grant is active and both frame_n and irdy_n are high. If any request is active, the winner is the first requesting master found by searching upward from the index after the last granted master, wrapping from the highest index to 0.
- R5: With no request active and the bus idle, the grant goes to master 0 and stays there.
- R6: The grant is removed at the next edge in two cases: when the owner's req_n is high and another master requests, or when the owner is not master 0 and no master requests.
- R7: The fairness counter is loaded from bits 15:8 when a grant is issued. It is armed at the first edge, while granted, where frame_n is sampled low after having been high. The grant is removed at the edge F+1 clocks after that arming edge (F being the loaded value), provided another master requests at that edge.
- R8: With a fairness value of 0, a requesting owner keeps its grant for as long as it requests, even while other masters request.
- R9: With bit 1 set, a requesting owner that has not driven frame_n low since its grant loses the grant at the 16th idle-bus clock edge after the grant edge. Once that owner has driven frame_n low, no timeout applies.
- R10: With bit 1 clear, an idle owner keeps its grant indefinitely while it requests.
- R11: With strap_ext high during reset, bit 0 reads 1, the register reads 0x0801 after reset, and all gnt_n bits stay high whatever the requests.
- R12: strap_ext is sampled only while rst_n is low. Changes to it after reset do not affect bit 0 or the grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_ext | input | 1 | Mode strap, high selects external arbitration (sampled in reset) |
| req_n | input | NUM_MST | Active-low bus requests, one per master |
| frame_n | input | 1 | Active-low FRAME# seen on the bus |
| irdy_n | input | 1 | Active-low IRDY# seen on the bus |
| gnt_n | output | NUM_MST | Active-low bus grants, at most one low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 16 | Register write value |
| cfg_rd_data | output | 16 | Register read value |

## Verification
On every cycle, the assertions check that no two grants are active together and that a handover always passes through a clock with no grant. They also check that a grant appears only after an idle bus sample, that an owner which stops requesting loses the grant when others wait, that external mode keeps every grant inactive, and that the mode bit never changes outside reset. The round-robin order, the exact clock on which the fairness counter or the broken-master timeout releases a grant, the zero-value and disabled cases, and strap relatching across resets depend on specific request and FRAME# sequences. Only the bench's table and directed scenarios can show these.

// File: rtl/sarb_pkg.sv
// Package: shared constants and types for the secondary bus arbiter.
// Assumes one 16-bit control register with an 8-bit fairness field.
package sarb_pkg;
    localparam int           FAIR_W      = 8;
    localparam int           CFG_W       = 16;
    localparam int           FAIR_LSB    = 8;
    localparam int           BMT_BIT     = 1;
    localparam int           MODE_BIT    = 0;
    localparam logic [7:0]   FAIR_RST    = 8'h08;

    // Ownership state of the bus grant
    typedef enum logic {
        OWN_NONE = 1'b0,
        OWN_HELD = 1'b1
    } own_state_e;

    // Decoded control register contents
    typedef struct packed {
        logic [FAIR_W-1:0] fair_init;
        logic              bmt_en;
        logic              ext_mode;
    } arb_cfg_t;
endpackage

// File: rtl/sarb_cfg_regs.sv
// Module: control register of the arbiter.
// Holds the fairness reload value and the timeout enable, and latches the
// mode strap while reset is low. Assumes whole-register writes.
module sarb_cfg_regs
    import sarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_ext,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output arb_cfg_t         cfg,
    output logic [CFG_W-1:0] rd_data
);
    localparam int RSV_W = FAIR_LSB - BMT_BIT - 1;

    logic [FAIR_W-1:0] fair_q;
    logic              bmt_q;
    logic              ext_q;
    logic              unused_wr_bits;

    // Register update: reset values, strap latch, software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fair_q <= FAIR_RST;
            bmt_q  <= 1'b0;
            ext_q  <= strap_ext;
        end else if (wr_en) begin
            fair_q <= wr_data[FAIR_LSB +: FAIR_W];
            bmt_q  <= wr_data[BMT_BIT];
        end
    end

    assign unused_wr_bits = ^{wr_data[FAIR_LSB-1:BMT_BIT+1], wr_data[MODE_BIT]};

    assign cfg.fair_init = fair_q;
    assign cfg.bmt_en    = bmt_q;
    assign cfg.ext_mode  = ext_q;
    assign rd_data       = {fair_q, {RSV_W{1'b0}}, bmt_q, ext_q};
endmodule

// File: rtl/sarb_rr_pick.sv
// Module: rotating-priority request picker.
// Searches the request vector upward from the slot after the last winner,
// wrapping at NUM_MST. Purely combinational; NUM_MST must be at least 2.
module sarb_rr_pick #(
    parameter int NUM_MST = 4,
    parameter int IW      = $clog2(NUM_MST)
) (
    input  logic [NUM_MST-1:0] req,
    input  logic [IW-1:0]      last,
    output logic               any,
    output logic [IW-1:0]      win
);
    // Linear search in rotated order for the first active request
    always_comb begin
        logic          found;
        logic [IW:0]   pos;
        logic [IW-1:0] idx;
        found = 1'b0;
        win   = '0;
        pos   = '0;
        idx   = '0;
        for (int k = 1; k <= NUM_MST; k++) begin
            pos = {1'b0, last} + (IW+1)'(k);
            if (pos >= (IW+1)'(NUM_MST)) begin
                pos = pos - (IW+1)'(NUM_MST);
            end
            idx = pos[IW-1:0];
            if (!found && req[idx]) begin
                found = 1'b1;
                win   = idx;
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/sarb_hold_timer.sv
// Module: grant hold limits.
// Fairness counter: loaded on each new grant, armed by the first FRAME#
// falling edge, then counts down to an expiry flag. Broken-master counter:
// counts idle clocks of a requesting owner that has not yet started.
// Assumes new_grant is only raised while the bus is idle.
module sarb_hold_timer
    import sarb_pkg::*;
#(
    parameter int BMT_CLOCKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_grant,
    input  logic              granted,
    input  logic              frame_n,
    input  logic              bus_idle,
    input  logic              own_req,
    input  logic [FAIR_W-1:0] fair_init,
    input  logic              bmt_en,
    output logic              fair_expire,
    output logic              bmt_expire
);
    localparam int            TW        = $clog2(BMT_CLOCKS);
    localparam logic [TW-1:0] TMO_LAST  = TW'(BMT_CLOCKS - 1);

    logic              frame_q;
    logic              frame_fall;
    logic              armed_q;
    logic              zero_q;
    logic [FAIR_W-1:0] fair_cnt_q;
    logic [TW-1:0]     tmo_cnt_q;
    logic              tmo_run;

    // FRAME# history for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= 1'b1;
        else        frame_q <= frame_n;
    end

    assign frame_fall = frame_q & ~frame_n;

    // Fairness counter: reload, arm on first FRAME# fall, then count down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fair_cnt_q <= '0;
            armed_q    <= 1'b0;
            zero_q     <= 1'b1;
        end else if (new_grant) begin
            fair_cnt_q <= fair_init;
            armed_q    <= 1'b0;
            zero_q     <= (fair_init == '0);
        end else if (granted) begin
            if (!armed_q && frame_fall) begin
                armed_q <= 1'b1;
            end else if (armed_q && fair_cnt_q != '0) begin
                fair_cnt_q <= fair_cnt_q - 1'b1;
            end
        end
    end

    assign fair_expire = granted & armed_q & (fair_cnt_q == '0) & ~zero_q;

    assign tmo_run = bmt_en & granted & ~armed_q & bus_idle & own_req;

    // Broken-master counter: counts idle clocks before the owner starts
    always_ff @(posedge clk) begin
        if (!rst_n)         tmo_cnt_q <= '0;
        else if (new_grant) tmo_cnt_q <= '0;
        else if (tmo_run)   tmo_cnt_q <= tmo_cnt_q + 1'b1;
    end

    assign bmt_expire = tmo_run & (tmo_cnt_q == TMO_LAST);
endmodule

// File: rtl/sec_bus_arbiter.sv
// Module: secondary bus arbiter top.
// Grants one master at a time in rotating order, parks on master 0, removes
// a grant when the owner stops requesting, when the fairness counter runs out
// with others waiting, or on broken-master timeout. A new grant is issued
// only on an idle bus with no grant active, which leaves one clock with no
// grant at every handover. External mode keeps all grants inactive.
module sec_bus_arbiter
    import sarb_pkg::*;
#(
    parameter int NUM_MST    = 4,
    parameter int BMT_CLOCKS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_ext,
    input  logic [NUM_MST-1:0] req_n,
    input  logic               frame_n,
    input  logic               irdy_n,
    output logic [NUM_MST-1:0] gnt_n,
    input  logic               cfg_wr_en,
    input  logic [CFG_W-1:0]   cfg_wr_data,
    output logic [CFG_W-1:0]   cfg_rd_data
);
    localparam int IW = $clog2(NUM_MST);

    arb_cfg_t           cfg;
    own_state_e         st_q;
    logic [IW-1:0]      own_q;
    logic [NUM_MST-1:0] req_act;
    logic [NUM_MST-1:0] own_dec;
    logic               granted;
    logic               bus_idle;
    logic               any_req;
    logic [IW-1:0]      rr_win;
    logic               own_req;
    logic               other_req;
    logic               drop;
    logic               fair_expire;
    logic               bmt_expire;
    logic               release_now;
    logic               grant_now;

    sarb_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_ext (strap_ext),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .cfg       (cfg),
        .rd_data   (cfg_rd_data)
    );

    assign req_act  = ~req_n;
    assign bus_idle = frame_n & irdy_n;
    assign granted  = (st_q == OWN_HELD);

    // Owner index decoded to one bit per master
    for (genvar g = 0; g < NUM_MST; g++) begin : g_own_dec
        assign own_dec[g] = (own_q == IW'(g));
    end

    sarb_rr_pick #(.NUM_MST(NUM_MST), .IW(IW)) u_pick (
        .req  (req_act),
        .last (own_q),
        .any  (any_req),
        .win  (rr_win)
    );

    assign own_req   = |(req_act & own_dec);
    assign other_req = |(req_act & ~own_dec);
    assign drop      = ~own_req & (any_req | (own_q != '0));

    sarb_hold_timer #(.BMT_CLOCKS(BMT_CLOCKS)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .new_grant   (grant_now),
        .granted     (granted),
        .frame_n     (frame_n),
        .bus_idle    (bus_idle),
        .own_req     (own_req),
        .fair_init   (cfg.fair_init),
        .bmt_en      (cfg.bmt_en),
        .fair_expire (fair_expire),
        .bmt_expire  (bmt_expire)
    );

    assign release_now = granted & (drop | (fair_expire & other_req) | bmt_expire);
    assign grant_now   = ~granted & bus_idle & ~cfg.ext_mode;

    // Grant ownership: release first, grant on a later idle clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= OWN_NONE;
            own_q <= '0;
        end else if (cfg.ext_mode || release_now) begin
            st_q  <= OWN_NONE;
        end else if (grant_now) begin
            st_q  <= OWN_HELD;
            own_q <= any_req ? rr_win : '0;
        end
    end

    assign gnt_n = ~(own_dec & {NUM_MST{granted}});
endmodule

// File: rtl/sec_bus_arbiter_chk.sv
// Module: property checker for the secondary bus arbiter, bound to the top.
// Observes ports only.
module sec_bus_arbiter_chk #(
    parameter int NUM_MST = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_MST-1:0] req_n,
    input logic               frame_n,
    input logic               irdy_n,
    input logic [NUM_MST-1:0] gnt_n,
    input logic [15:0]        cfg_rd_data
);
    // R3
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gnt_n));

    // R3
    dead_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_n != '1) && ($past(gnt_n) != '1)) |-> (gnt_n == $past(gnt_n)));

    // R4
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(gnt_n) == '1) && (gnt_n != '1)) |-> $past(frame_n && irdy_n));

    // R6
    owner_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_n != '1) && ((~gnt_n & ~req_n) == '0) && (req_n != '1))
        |=> (gnt_n == '1));

    // R11
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[0] |-> (gnt_n == '1));

    // R12
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_rd_data[0]));
endmodule

bind sec_bus_arbiter sec_bus_arbiter_chk #(.NUM_MST(NUM_MST)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n       (req_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .gnt_n       (gnt_n),
    .cfg_rd_data (cfg_rd_data)
);

// File: tb/sec_bus_arbiter_tb_top.sv
// Bench: cycle table for arbitration order, then directed reset, fairness,
// timeout and strap tests. Inputs change and outputs are sampled at negedge.
module sec_bus_arbiter_tb_top;
    localparam int NM = 4;
    localparam int NV = 23;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strap_ext;
    logic [NM-1:0] req_n;
    logic          frame_n;
    logic          irdy_n;
    logic [NM-1:0] gnt_n;
    logic          cfg_wr_en;
    logic [15:0]   cfg_wr_data;
    logic [15:0]   cfg_rd_data;
    int            checks = 0;
    int            errors = 0;
    bit            done   = 1'b0;

    always #5 clk = ~clk;

    sec_bus_arbiter #(.NUM_MST(NM)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_ext   (strap_ext),
        .req_n       (req_n),
        .frame_n     (frame_n),
        .irdy_n      (irdy_n),
        .gnt_n       (gnt_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data)
    );

    // Per clock: {req_n, frame_n, irdy_n, expected gnt_n}; fairness value 2
    localparam logic [9:0] VEC [NV] = '{
        10'b1101_1_1_1111, 10'b1101_1_1_1101, 10'b1101_0_1_1101,
        10'b1001_0_0_1101, 10'b1001_0_0_1101, 10'b1001_1_0_1111,
        10'b1001_1_1_1011, 10'b1001_1_1_1011, 10'b1011_0_1_1011,
        10'b1011_1_0_1011, 10'b1111_1_1_1111, 10'b1111_1_1_1110,
        10'b0110_1_1_1110, 10'b0110_0_1_1110, 10'b0110_0_0_1110,
        10'b0110_0_0_1110, 10'b0110_0_0_1111, 10'b0110_0_0_1111,
        10'b0110_1_0_1111, 10'b0110_1_1_0111, 10'b1110_1_1_1111,
        10'b1110_1_1_1110, 10'b1111_1_1_1110
    };

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic cyc(input logic [NM-1:0] r, input logic f, input logic i);
        req_n   = r;
        frame_n = f;
        irdy_n  = i;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [15:0] d);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic do_reset(input logic s);
        rst_n     = 1'b0;
        strap_ext = s;
        req_n     = '1;
        frame_n   = 1'b1;
        irdy_n    = 1'b1;
        repeat (3) @(negedge clk);
        check({12'h000, gnt_n}, 16'h000F, "R1 grants inactive in reset");
        rst_n = 1'b1;
    endtask

    initial begin
        bit held;
        cfg_wr_en   = 1'b0;
        cfg_wr_data = '0;
        @(negedge clk);

        do_reset(1'b0);
        check(cfg_rd_data, 16'h0800, "R1 reset value internal mode");
        cyc(4'b1111, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000E, "R5 park on master 0 after reset");
        cfg_write(16'h0200);
        check(cfg_rd_data, 16'h0200, "R2 fairness field write");

        for (int v = 0; v < NV; v++) begin
            cyc(VEC[v][9:6], VEC[v][5], VEC[v][4]);
            check({12'h000, gnt_n}, {12'h000, VEC[v][3:0]},
                  $sformatf("R3 R4 R5 R6 R7 table vector %0d", v));
        end

        // Fairness value zero
        cfg_write(16'h0000);
        check(cfg_rd_data, 16'h0000, "R2 fairness zero write");
        cyc(4'b1101, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000F, "R6 parked grant released");
        cyc(4'b1101, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000D, "R4 grant to master 1");
        cyc(4'b1101, 1'b0, 1'b1);
        held = 1'b1;
        for (int k = 0; k < 40; k++) begin
            cyc(4'b1001, 1'b0, 1'b0);
            if (gnt_n !== 4'b1101) held = 1'b0;
        end
        check({15'h0, held}, 16'h0001, "R8 grant kept with fairness zero");
        cyc(4'b1011, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000F, "R6 owner dropped request");
        cyc(4'b1011, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000B, "R4 grant to master 2");
        cyc(4'b1111, 1'b1, 1'b1);
        cyc(4'b1111, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000E, "R5 return to park");

        // Broken-master timeout enabled
        cfg_write(16'h0802);
        check(cfg_rd_data, 16'h0802, "R2 timeout enable write");
        cyc(4'b1101, 1'b1, 1'b1);
        cyc(4'b1101, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000D, "R9 grant before timeout");
        held = 1'b1;
        for (int k = 0; k < 15; k++) begin
            cyc(4'b1101, 1'b1, 1'b1);
            if (gnt_n !== 4'b1101) held = 1'b0;
        end
        check({15'h0, held}, 16'h0001, "R9 grant kept for 15 idle clocks");
        cyc(4'b1101, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000F, "R9 timeout at 16th idle clock");
        cyc(4'b1101, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000D, "R9 regrant after timeout");
        cyc(4'b1101, 1'b0, 1'b1);
        held = 1'b1;
        for (int k = 0; k < 20; k++) begin
            cyc(4'b1101, 1'b1, 1'b1);
            if (gnt_n !== 4'b1101) held = 1'b0;
        end
        check({15'h0, held}, 16'h0001, "R9 no timeout after FRAME# seen");
        cyc(4'b1111, 1'b1, 1'b1);
        cyc(4'b1111, 1'b1, 1'b1);

        // Broken-master timeout disabled
        cfg_write(16'h0800);
        cyc(4'b1101, 1'b1, 1'b1);
        cyc(4'b1101, 1'b1, 1'b1);
        held = 1'b1;
        for (int k = 0; k < 30; k++) begin
            cyc(4'b1101, 1'b1, 1'b1);
            if (gnt_n !== 4'b1101) held = 1'b0;
        end
        check({15'h0, held}, 16'h0001, "R10 idle owner kept without timeout");
        cyc(4'b1111, 1'b1, 1'b1);
        cyc(4'b1111, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000E, "R5 park after release");

        cfg_write(16'hFFFF);
        check(cfg_rd_data, 16'hFF02, "R2 reserved and status bits not writable");
        cfg_write(16'h0800);

        // External arbiter mode
        do_reset(1'b1);
        check(cfg_rd_data, 16'h0801, "R11 reset value external mode");
        held = 1'b1;
        for (int k = 0; k < 5; k++) begin
            cyc(4'b0000, 1'b1, 1'b1);
            if (gnt_n !== 4'b1111) held = 1'b0;
        end
        check({15'h0, held}, 16'h0001, "R11 no grant in external mode");
        cfg_write(16'h0000);
        check(cfg_rd_data, 16'h0001, "R11 status bit survives write");
        strap_ext = 1'b0;
        for (int k = 0; k < 5; k++) cyc(4'b0000, 1'b1, 1'b1);
        check(cfg_rd_data, 16'h0001, "R12 strap change after reset ignored");
        check({12'h000, gnt_n}, 16'h000F, "R12 grants stay inactive");
        do_reset(1'b0);
        check(cfg_rd_data, 16'h0800, "R12 strap relatched in reset");
        cyc(4'b1111, 1'b1, 1'b1);
        check({12'h000, gnt_n}, 16'h000E, "R12 internal mode parks again");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule